// File: doc/BRIEF.md
# Load/Store Address Generator

This block forms the effective address for every memory operation of a compact 16-bit-encoded instruction stream. It also forms the result of the PC-relative add, which uses the same adder but does not touch memory. A decoded request supplies three things: an access size, a base selector and a raw offset. The base is one of three values: a general register, the stack pointer, or the program counter. When the instruction sits in a jump's delay slot, the saved jump address takes the place of the program counter. The raw offset is zero-extended and scaled by the access size. The PC-relative add is the exception: its offset is sign-extended and scaled by four.

For each request, the block registers several results: the address, little-endian byte strobes, a misalignment flag and store data already moved into its byte lanes. A misaligned halfword or word access is flagged and no memory access is made. For loads, the block keeps the lane and size of the most recent access it issued. When read data comes back on the read bus, the block takes the addressed lanes, right-aligns them, and sign- or zero-extends them for register write-back.

Top module: `lsu_agen`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `out_valid`, `out_mem` and `wb_valid` are 0.
- R2: With base code 0 (register), `out_addr` is `base_reg + (zero-extended req_off[4:0] << s)`. Here s is 0 for size code 0 (byte), 1 for size code 1 (half), and 2 for size codes 2 (word) and 3. Offset bits 7:5 have no effect. The result appears the cycle after `req_valid`.
- R3: With base code 1 (stack pointer), `out_addr` is `sp_val + (zero-extended req_off[7:0] << s)`.
- R4: With base code 2 (PC), the base is `cur_pc` with bits 1:0 cleared. When `in_delay` is 1, `jump_pc` with bits 1:0 cleared is used instead. The base plus `(zero-extended req_off[7:0] << s)` gives `out_addr`.
- R5: With base code 3 (PC add), `out_addr` is the aligned PC base of R4 plus `(sign-extended req_off[7:0] << 2)`. In this case `out_pcadd` is 1, and `out_mem`, `out_store`, `out_misalign` and `out_strobe` are 0, whatever the size and store inputs are.
- R6: For an aligned access at lane L = `out_addr[1:0]`, `out_strobe` is `1<<L` for a byte, `3<<L` for a half and `4'hF` for a word, and `out_mem` is 1.
- R7: A half with `out_addr[0]`=1, or a word with `out_addr[1:0]`≠0, sets `out_misalign` and forces `out_mem` to 0 and `out_strobe` to 0.
- R8: `out_store` follows `req_store` for memory forms. `out_wdata` is `store_val << (8*L)`.
- R9: One cycle after `rd_valid`, `wb_valid` is 1 and `wb_data` holds the lanes of `rd_data` chosen by the last aligned load that issued in an earlier cycle, right-aligned. Byte and half results are zero-extended when `req_unsigned` was 1 for that load and sign-extended otherwise. Misaligned loads and stores leave this context unchanged.
- R10: A cycle without `req_valid` gives `out_valid`=0, `out_mem`=0 and `out_pcadd`=0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_size | input | 2 | 0 byte, 1 half, 2 word, 3 treated as word |
| req_base | input | 2 | 0 register, 1 stack pointer, 2 PC, 3 PC add |
| req_store | input | 1 | 1 for a store, 0 for a load |
| req_unsigned | input | 1 | Zero-extend load result |
| req_off | input | 8 | Raw offset field |
| base_reg | input | 32 | Base register value |
| sp_val | input | 32 | Stack pointer value |
| cur_pc | input | 32 | Address of current instruction |
| in_delay | input | 1 | Instruction executes in a delay slot |
| jump_pc | input | 32 | Saved address of the preceding jump |
| store_val | input | 32 | Store source value |
| rd_valid | input | 1 | Read data present |
| rd_data | input | 32 | Read bus |
| out_valid | output | 1 | Registered result present |
| out_addr | output | 32 | Effective address or PC-add sum |
| out_mem | output | 1 | Memory access to perform |
| out_store | output | 1 | Access is a write |
| out_strobe | output | 4 | Byte-lane enables |
| out_misalign | output | 1 | Access suppressed for misalignment |
| out_pcadd | output | 1 | Result is a PC-add sum |
| out_wdata | output | 32 | Lane-placed store data |
| wb_valid | output | 1 | Write-back data present |
| wb_data | output | 32 | Extended load result |

## Verification
All address-side results are due exactly one clock after the request cycle, and write-back data is due one clock after the read-data cycle. Each time the driver presents a cycle at the falling edge, it queues one expected entry for that cycle, including idle cycles. The monitor pops one entry per rising edge, a short delay after the edge, so each comparison lines up with the register stage that produces it. The load context the bench uses to predict write-back data is updated only after read data of the same cycle has been predicted. This matches the rule that a load affects only read data that arrives later.

// File: rtl/agen_pkg.sv
package agen_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    SRC_REG   = 2'd0,
    SRC_SP    = 2'd1,
    SRC_PC    = 2'd2,
    SRC_PCADD = 2'd3
  } base_src_e;

  // The reserved size code behaves as a word access.
  function automatic logic [1:0] norm_size(input logic [1:0] sz);
    return (sz == SZ_RSVD) ? 2'(SZ_WORD) : sz;
  endfunction

endpackage

// File: rtl/agen_base_sel.sv
module agen_base_sel
  import agen_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [1:0]        base_src,
  input  logic [ADDR_W-1:0] base_reg,
  input  logic [ADDR_W-1:0] sp_val,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic              in_delay,
  input  logic [ADDR_W-1:0] jump_pc,
  output logic [ADDR_W-1:0] base
);

  localparam logic [ADDR_W-1:0] PC_ALIGN_MASK = ~ADDR_W'(3);

  logic [ADDR_W-1:0] pc_eff;
  logic [ADDR_W-1:0] pc_aligned;

  // A delay-slot instruction takes the jump's address as its PC.
  assign pc_eff     = in_delay ? jump_pc : cur_pc;
  assign pc_aligned = pc_eff & PC_ALIGN_MASK;

  always_comb begin
    unique case (base_src_e'(base_src))
      SRC_REG:   base = base_reg;
      SRC_SP:    base = sp_val;
      SRC_PC:    base = pc_aligned;
      SRC_PCADD: base = pc_aligned;
      default:   base = base_reg;
    endcase
  end

endmodule

// File: rtl/agen_offset.sv
module agen_offset
  import agen_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int REG_OFF_W  = 5,
  parameter int WIDE_OFF_W = 8
) (
  input  logic [1:0]            base_src,
  input  logic [1:0]            size_n,
  input  logic [WIDE_OFF_W-1:0] raw_off,
  output logic [ADDR_W-1:0]     off_scaled
);

  localparam int EXT_W = ADDR_W - WIDE_OFF_W;
  localparam int PCADD_SHIFT = 2;

  logic [ADDR_W-1:0] narrow_z;
  logic [ADDR_W-1:0] wide_z;
  logic [ADDR_W-1:0] wide_s;

  assign narrow_z = ADDR_W'(raw_off[REG_OFF_W-1:0]);
  assign wide_z   = ADDR_W'(raw_off);
  assign wide_s   = {{EXT_W{raw_off[WIDE_OFF_W-1]}}, raw_off};

  always_comb begin
    unique case (base_src_e'(base_src))
      SRC_REG:   off_scaled = narrow_z << size_n;
      SRC_SP:    off_scaled = wide_z << size_n;
      SRC_PC:    off_scaled = wide_z << size_n;
      SRC_PCADD: off_scaled = wide_s << PCADD_SHIFT;
      default:   off_scaled = narrow_z << size_n;
    endcase
  end

endmodule

// File: rtl/agen_lane_ctl.sv
module agen_lane_ctl #(
  parameter int DATA_W = 32,
  localparam int LANES  = DATA_W / 8,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic [LANE_W-1:0] lane,
  input  logic [1:0]        size_n,
  input  logic [DATA_W-1:0] store_val,
  output logic [LANES-1:0]  strobe,
  output logic              misalign,
  output logic [DATA_W-1:0] wdata
);

  logic [LANE_W-1:0] low_mask;
  logic [LANES-1:0]  strobe_raw;

  // Bits of the lane index that must be zero for the chosen size.
  assign low_mask = LANE_W'((1 << size_n) - 1);
  assign misalign = |(lane & low_mask);

  // A lane is enabled when it shares the access's size-aligned group.
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign strobe_raw[i] = ((LANE_W'(i) >> size_n) == (lane >> size_n));
  end

  assign strobe = misalign ? '0 : strobe_raw;
  assign wdata  = store_val << {lane, 3'b000};

endmodule

// File: rtl/agen_load_fmt.sv
module agen_load_fmt
  import agen_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES  = DATA_W / 8,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic [DATA_W-1:0] rd_data,
  input  logic [LANE_W-1:0] lane,
  input  logic [1:0]        size_n,
  input  logic              is_unsigned,
  output logic [DATA_W-1:0] result
);

  logic [DATA_W-1:0] shifted;
  logic              fill_b;
  logic              fill_h;

  assign shifted = rd_data >> {lane, 3'b000};
  assign fill_b  = ~is_unsigned & shifted[7];
  assign fill_h  = ~is_unsigned & shifted[15];

  always_comb begin
    unique case (acc_size_e'(size_n))
      SZ_BYTE: result = {{(DATA_W-8){fill_b}}, shifted[7:0]};
      SZ_HALF: result = {{(DATA_W-16){fill_h}}, shifted[15:0]};
      default: result = shifted;
    endcase
  end

endmodule

// File: rtl/lsu_agen.sv
module lsu_agen
  import agen_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int REG_OFF_W  = 5,
  parameter int WIDE_OFF_W = 8,
  localparam int LANES  = DATA_W / 8,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic [1:0]            req_size,
  input  logic [1:0]            req_base,
  input  logic                  req_store,
  input  logic                  req_unsigned,
  input  logic [WIDE_OFF_W-1:0] req_off,
  input  logic [ADDR_W-1:0]     base_reg,
  input  logic [ADDR_W-1:0]     sp_val,
  input  logic [ADDR_W-1:0]     cur_pc,
  input  logic                  in_delay,
  input  logic [ADDR_W-1:0]     jump_pc,
  input  logic [DATA_W-1:0]     store_val,
  input  logic                  rd_valid,
  input  logic [DATA_W-1:0]     rd_data,
  output logic                  out_valid,
  output logic [ADDR_W-1:0]     out_addr,
  output logic                  out_mem,
  output logic                  out_store,
  output logic [LANES-1:0]      out_strobe,
  output logic                  out_misalign,
  output logic                  out_pcadd,
  output logic [DATA_W-1:0]     out_wdata,
  output logic                  wb_valid,
  output logic [DATA_W-1:0]     wb_data
);

  logic [1:0]        size_n;
  logic              is_pcadd;
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] off_scaled;
  logic [ADDR_W-1:0] eff_addr;
  logic [LANES-1:0]  lane_strobe;
  logic              lane_mis;
  logic [DATA_W-1:0] lane_wdata;
  logic              mem_ok;
  logic              mis_hit;

  // Context of the last aligned load, used to format returning data.
  logic [LANE_W-1:0] ctx_lane;
  logic [1:0]        ctx_size;
  logic              ctx_uns;
  logic [DATA_W-1:0] fmt_data;

  assign size_n   = norm_size(req_size);
  assign is_pcadd = (base_src_e'(req_base) == SRC_PCADD);

  agen_base_sel #(.ADDR_W(ADDR_W)) u_base (
    .base_src (req_base),
    .base_reg (base_reg),
    .sp_val   (sp_val),
    .cur_pc   (cur_pc),
    .in_delay (in_delay),
    .jump_pc  (jump_pc),
    .base     (base)
  );

  agen_offset #(
    .ADDR_W     (ADDR_W),
    .REG_OFF_W  (REG_OFF_W),
    .WIDE_OFF_W (WIDE_OFF_W)
  ) u_off (
    .base_src   (req_base),
    .size_n     (size_n),
    .raw_off    (req_off),
    .off_scaled (off_scaled)
  );

  assign eff_addr = base + off_scaled;

  agen_lane_ctl #(.DATA_W(DATA_W)) u_lane (
    .lane      (eff_addr[LANE_W-1:0]),
    .size_n    (size_n),
    .store_val (store_val),
    .strobe    (lane_strobe),
    .misalign  (lane_mis),
    .wdata     (lane_wdata)
  );

  assign mis_hit = req_valid & ~is_pcadd & lane_mis;
  assign mem_ok  = req_valid & ~is_pcadd & ~lane_mis;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_addr     <= '0;
      out_mem      <= 1'b0;
      out_store    <= 1'b0;
      out_strobe   <= '0;
      out_misalign <= 1'b0;
      out_pcadd    <= 1'b0;
      out_wdata    <= '0;
    end else begin
      out_valid    <= req_valid;
      out_addr     <= eff_addr;
      out_mem      <= mem_ok;
      out_store    <= req_valid & ~is_pcadd & req_store;
      out_strobe   <= mem_ok ? lane_strobe : '0;
      out_misalign <= mis_hit;
      out_pcadd    <= req_valid & is_pcadd;
      out_wdata    <= lane_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctx_lane <= '0;
      ctx_size <= 2'(SZ_WORD);
      ctx_uns  <= 1'b0;
    end else if (mem_ok && !req_store) begin
      ctx_lane <= eff_addr[LANE_W-1:0];
      ctx_size <= size_n;
      ctx_uns  <= req_unsigned;
    end
  end

  agen_load_fmt #(.DATA_W(DATA_W)) u_fmt (
    .rd_data     (rd_data),
    .lane        (ctx_lane),
    .size_n      (ctx_size),
    .is_unsigned (ctx_uns),
    .result      (fmt_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_valid <= 1'b0;
      wb_data  <= '0;
    end else begin
      wb_valid <= rd_valid;
      wb_data  <= fmt_data;
    end
  end

endmodule

// File: rtl/lsu_agen_chk.sv
module lsu_agen_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             rd_valid,
  input logic             out_valid,
  input logic [1:0]       out_addr_lo,
  input logic             out_mem,
  input logic             out_store,
  input logic [LANES-1:0] out_strobe,
  input logic             out_misalign,
  input logic             out_pcadd,
  input logic             wb_valid
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_mem && !wb_valid));

  // R5
  pcadd_no_access_chk: assert property (@(posedge clk) disable iff (rst)
    out_pcadd |-> (!out_mem && !out_store && !out_misalign && out_addr_lo == 2'b00));

  // R6
  strobe_shape_chk: assert property (@(posedge clk) disable iff (rst)
    out_mem |-> ($countones(out_strobe) == 1 || $countones(out_strobe) == 2
                 || $countones(out_strobe) == LANES));

  // R7
  misalign_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    out_misalign |-> (!out_mem && out_strobe == '0 && out_valid));

  // R9
  wb_follows_read_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> wb_valid);

  // R9
  wb_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |=> !wb_valid);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!out_valid && !out_mem && !out_pcadd));

endmodule

bind lsu_agen lsu_agen_chk #(.LANES(LANES)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .rd_valid     (rd_valid),
  .out_valid    (out_valid),
  .out_addr_lo  (out_addr[1:0]),
  .out_mem      (out_mem),
  .out_store    (out_store),
  .out_strobe   (out_strobe),
  .out_misalign (out_misalign),
  .out_pcadd    (out_pcadd),
  .wb_valid     (wb_valid)
);

// File: tb/lsu_agen_tb.sv
module lsu_agen_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        req_valid = 0, req_store = 0, req_unsigned = 0, in_delay = 0, rd_valid = 0;
  logic [1:0]  req_size = 0, req_base = 0;
  logic [7:0]  req_off = 0;
  logic [31:0] base_reg = 0, sp_val = 0, cur_pc = 0, jump_pc = 0, store_val = 0, rd_data = 0;
  logic        out_valid, out_mem, out_store, out_misalign, out_pcadd, wb_valid;
  logic [31:0] out_addr, out_wdata, wb_data;
  logic [3:0]  out_strobe;

  lsu_agen u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_size(req_size),
    .req_base(req_base), .req_store(req_store), .req_unsigned(req_unsigned),
    .req_off(req_off), .base_reg(base_reg), .sp_val(sp_val), .cur_pc(cur_pc),
    .in_delay(in_delay), .jump_pc(jump_pc), .store_val(store_val),
    .rd_valid(rd_valid), .rd_data(rd_data), .out_valid(out_valid),
    .out_addr(out_addr), .out_mem(out_mem), .out_store(out_store),
    .out_strobe(out_strobe), .out_misalign(out_misalign), .out_pcadd(out_pcadd),
    .out_wdata(out_wdata), .wb_valid(wb_valid), .wb_data(wb_data)
  );

  int n_checks = 0;
  int n_fail   = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  typedef struct {
    logic        v;
    logic [31:0] addr;
    logic        mem, mis, pc, st;
    logic [3:0]  stb;
    logic [31:0] wd;
    logic        wv;
    logic [31:0] wbd;
  } exp_t;

  exp_t  expq[$];
  string tagq[$];

  // Staged stimulus, applied at the next falling edge.
  logic        s_valid = 0, s_store = 0, s_uns = 0, s_dly = 0, s_rv = 0;
  logic [1:0]  s_size = 0, s_base = 0;
  logic [7:0]  s_off = 0;
  logic [31:0] s_breg = 32'h1000, s_sp = 32'h7FF0, s_pc = 32'h4002, s_jpc = 32'h5006;
  logic [31:0] s_sval = 0, s_rdd = 0;

  // Bench copy of the load context (R9)
  logic [1:0] m_lane = 0, m_size = 2;
  logic       m_uns = 0;

  function automatic exp_t model();
    exp_t e;
    logic [31:0] pcb, base, off;
    logic [1:0]  sz, ln;
    e = '{default: '0};
    e.v  = s_valid;
    pcb  = (s_dly ? s_jpc : s_pc) & ~32'd3;
    sz   = (s_size == 2'd3) ? 2'd2 : s_size;
    if (s_base == 2'd3) begin
      e.addr = pcb + ({{24{s_off[7]}}, s_off} << 2);
      e.pc   = s_valid;
    end else begin
      base = (s_base == 2'd0) ? s_breg : (s_base == 2'd1) ? s_sp : pcb;
      off  = (s_base == 2'd0) ? {27'd0, s_off[4:0]} : {24'd0, s_off};
      e.addr = base + (off << sz);
      ln     = e.addr[1:0];
      e.mis  = s_valid && ((sz == 2'd1 && ln[0]) || (sz == 2'd2 && ln != 2'd0));
      e.mem  = s_valid && !e.mis;
      e.st   = s_valid && s_store;
      e.stb  = !e.mem ? 4'h0 : (sz == 2'd0) ? (4'h1 << ln) : (sz == 2'd1) ? (4'h3 << ln) : 4'hF;
      e.wd   = s_sval << (8 * ln);
    end
    e.wv = s_rv;
    if (s_rv) begin
      logic [31:0] sh;
      sh = s_rdd >> (8 * m_lane);
      if (m_size == 2'd0)      e.wbd = {{24{~m_uns & sh[7]}}, sh[7:0]};
      else if (m_size == 2'd1) e.wbd = {{16{~m_uns & sh[15]}}, sh[15:0]};
      else                     e.wbd = sh;
    end
    return e;
  endfunction

  task automatic issue(input string tag);
    exp_t e;
    @(negedge clk);
    req_valid = s_valid; req_size = s_size; req_base = s_base; req_store = s_store;
    req_unsigned = s_uns; req_off = s_off; base_reg = s_breg; sp_val = s_sp;
    cur_pc = s_pc; in_delay = s_dly; jump_pc = s_jpc; store_val = s_sval;
    rd_valid = s_rv; rd_data = s_rdd;
    e = model();
    expq.push_back(e);
    tagq.push_back(tag);
    if (e.mem && !s_store) begin
      m_lane = e.addr[1:0];
      m_size = (s_size == 2'd3) ? 2'd2 : s_size;
      m_uns  = s_uns;
    end
    s_valid = 0; s_rv = 0;
  endtask

  task automatic req(input logic [1:0] sz, input logic [1:0] b, input logic st,
                     input logic uns, input logic [7:0] off, input string tag);
    s_valid = 1; s_size = sz; s_base = b; s_store = st; s_uns = uns; s_off = off;
    issue(tag);
  endtask

  task automatic idle(input string tag);
    issue(tag);
  endtask

  // Monitor: results are due one rising edge after the driving cycle.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expq.size() > 0) begin
        exp_t e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        chk(out_valid == e.v, {t, " valid"}, 32'(out_valid), 32'(e.v));
        chk(out_mem == e.mem, {t, " mem"}, 32'(out_mem), 32'(e.mem));
        chk(wb_valid == e.wv, {t, " wb_valid"}, 32'(wb_valid), 32'(e.wv));
        if (e.v) begin
          chk(out_addr == e.addr, {t, " addr"}, out_addr, e.addr);
          chk(out_pcadd == e.pc, {t, " pcadd"}, 32'(out_pcadd), 32'(e.pc));
          chk(out_misalign == e.mis, {t, " misalign"}, 32'(out_misalign), 32'(e.mis));
          chk(out_strobe == e.stb, {t, " strobe"}, 32'(out_strobe), 32'(e.stb));
          chk(out_store == e.st, {t, " store"}, 32'(out_store), 32'(e.st));
          if (e.mem && e.st) chk(out_wdata == e.wd, {t, " wdata"}, out_wdata, e.wd);
        end
        if (e.wv) chk(wb_data == e.wbd, {t, " wb_data"}, wb_data, e.wbd);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 0, "R1 out_valid", 32'(out_valid), 0);
    chk(out_mem == 0, "R1 out_mem", 32'(out_mem), 0);
    chk(wb_valid == 0, "R1 wb_valid", 32'(wb_valid), 0);
    rst = 0;
    @(negedge clk);
    chk(out_valid == 0 && wb_valid == 0, "R1 after release", 32'(out_valid), 0);

    // R2 register base, offset scaled by size, upper offset bits ignored
    req(0, 0, 0, 0, 8'd5, "R2 byte");
    req(1, 0, 0, 0, 8'd3, "R2 half");
    req(2, 0, 0, 0, 8'd31, "R2 word");
    req(0, 0, 0, 0, 8'hE5, "R2 high bits ignored");
    req(3, 0, 0, 0, 8'd2, "R2 size3 as word");
    // R3 stack pointer base
    req(2, 1, 0, 0, 8'hFF, "R3 word");
    req(0, 1, 1, 0, 8'h81, "R3 byte store");
    // R4 PC base, delay slot
    req(2, 2, 0, 0, 8'd2, "R4 pc");
    s_dly = 1;
    req(2, 2, 0, 0, 8'd2, "R4 delay slot");
    s_dly = 0;
    // R5 PC add
    req(0, 3, 1, 0, 8'hFF, "R5 minus one");
    req(1, 3, 0, 0, 8'h7F, "R5 max positive");
    s_dly = 1;
    req(2, 3, 0, 0, 8'h80, "R5 delay slot");
    s_dly = 0;
    // R6 strobes
    s_breg = 32'h2000;
    for (int i = 0; i < 4; i++) req(0, 0, 0, 0, 8'(i), "R6 byte lane");
    req(1, 0, 0, 0, 8'd0, "R6 half lane0");
    req(1, 0, 0, 0, 8'd1, "R6 half lane2");
    req(2, 0, 0, 0, 8'd0, "R6 word");
    // R7 misalignment
    s_breg = 32'h1001;
    req(1, 0, 0, 0, 8'd0, "R7 half odd");
    req(2, 0, 1, 0, 8'd0, "R7 word odd store");
    s_breg = 32'h1002;
    req(2, 0, 0, 0, 8'd0, "R7 word lane2");
    req(1, 0, 0, 0, 8'd0, "R7 half lane2 ok");
    // R8 store data placement
    s_breg = 32'h3000;
    s_sval = 32'h000000AB; req(0, 0, 1, 0, 8'd2, "R8 byte lane2");
    s_sval = 32'h00001234; req(1, 0, 1, 0, 8'd1, "R8 half lane2");
    s_sval = 32'hDEADBEEF; req(2, 0, 1, 0, 8'd0, "R8 word");
    s_sval = 0;
    // R9 load formatting
    s_breg = 32'h6000;
    req(0, 0, 0, 0, 8'd3, "R9 lb issue");
    s_rv = 1; s_rdd = 32'h80112233; idle("R9 lb signed");
    req(0, 0, 0, 1, 8'd3, "R9 lbu issue");
    s_rv = 1; s_rdd = 32'h80112233; idle("R9 lbu zero");
    req(1, 0, 0, 0, 8'd1, "R9 lh issue");
    s_rv = 1; s_rdd = 32'h9ABC1234; req(1, 0, 0, 1, 8'd1, "R9 lh with lhu issue");
    s_rv = 1; s_rdd = 32'h9ABC1234; idle("R9 lhu zero");
    req(2, 0, 0, 0, 8'd0, "R9 lw issue");
    s_rv = 1; s_rdd = 32'hCAFEF00D; idle("R9 lw");
    req(0, 0, 0, 0, 8'd1, "R9 lb lane1 issue");
    s_breg = 32'h6001;
    req(1, 0, 0, 0, 8'd0, "R9 misaligned lh");
    s_breg = 32'h6000;
    s_sval = 32'h55; req(0, 0, 1, 0, 8'd0, "R9 store keeps ctx");
    s_rv = 1; s_rdd = 32'h0000F700; idle("R9 ctx kept");
    // R10 idle cycles
    idle("R10 idle");
    idle("R10 idle");
    repeat (3) @(posedge clk);
    #2;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule